// File: doc/BRIEF.md
# Path Probability Throttle Tracker

This block keeps a running estimate of the probability that every speculative branch now in flight has been predicted correctly. From that estimate it names the block from which memory accesses should be held back. Each fetched branch brings a 6-bit confidence value and gets the next block ID. Each resolved branch brings its block ID and a correct or mispredicted flag. A per-confidence correct-prediction rate comes from an external lookup port that answers within the same cycle. The load/store side reads the throttle bit and the throttle block ID, and it holds back requests from blocks at or after that ID while the bit is set.

The estimate is a product of rates. A branch's rate is multiplied in when the branch joins the tracked prefix and divided back out when that branch stops being speculative. Rates and the estimate are unsigned Q0.16 fractions, with 0xFFFF standing for one. Division runs on a serial unit. When the throttle clears behind newer fetched blocks, a walk advances the throttle point by one block per cycle. New events wait while either of these is in progress.

Top module: `path_prob_throttle`

## Requirements
- R1: After reset `path_prob` is 0xFFFF, `thr_on` is 0, `thr_blk` is 0, `evt_rdy` is 1, and the threshold holds its reset value 0x4000.
- R2: An accepted fetch gets the block ID one above the newest ID modulo 256, counting from 0 after reset. When `thr_on` was clear, `thr_blk` shows that ID in the next cycle.
- R3: On an accepted fetch with `thr_on` clear, `rate_conf` equals `fetch_conf` in that cycle. The estimate becomes floor(p·rate/65536), and `thr_on` is set exactly when the new estimate is below the threshold.
- R4: An accepted fetch while `thr_on` is set leaves `path_prob`, `thr_blk` and `thr_on` unchanged.
- R5: A correct resolution of a pending block at or before `thr_blk` replaces the estimate by min(0xFFFF, floor(p·65536/rate)), with rate 0 giving 0xFFFF, and re-evaluates `thr_on`. A correct resolution of a block after `thr_blk`, or of a block no longer pending, leaves the estimate unchanged. Either way the block stops being pending.
- R6: While `thr_on` is clear and `thr_blk` is behind the newest ID, `thr_blk` advances one block per cycle. Each still-pending block it reaches multiplies its rate into the estimate. The walk stops once `thr_on` sets or the newest ID is reached.
- R7: A misprediction at ID m divides out, oldest first, the rates of the pending blocks from m through `thr_blk`. It then discards blocks m and later, so the next fetch gets m+1. `thr_blk` becomes m if it was at or after m, and `thr_on` is re-evaluated.
- R8: Block ID order is modular. It is measured from newest−127, so the throttle logic stays correct when IDs wrap from 255 to 0, given at most 128 IDs in flight.
- R9: `evt_rdy` is low while a division or a walk is in progress. Fetch or resolution inputs offered while it is low are ignored. A fetch takes precedence over a resolution offered in the same cycle.
- R10: A `thr_ld` pulse loads `thr_val` into the threshold, and every later evaluation of `thr_on` uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_ld | input | 1 | Load threshold |
| thr_val | input | 16 | Threshold value, Q0.16 |
| fetch_vld | input | 1 | Branch fetched this cycle |
| fetch_conf | input | 6 | Confidence of the fetched branch |
| res_vld | input | 1 | Branch resolved this cycle |
| res_id | input | 8 | Block ID of the resolved branch |
| res_ok | input | 1 | 1 means correctly predicted, 0 means mispredicted |
| rate_conf | output | 6 | Confidence value being looked up |
| rate_val | input | 16 | Correct-prediction rate for `rate_conf`, Q0.16 |
| evt_rdy | output | 1 | Fetch and resolution are accepted in this cycle |
| thr_blk | output | 8 | Throttle block ID |
| thr_on | output | 1 | Throttle active |
| path_prob | output | 16 | Current path probability, Q0.16 |

## Verification
A wrong table entry or a wrong throttle point does not show up at once. It shows at the next resolution or walk step that touches that block, as a `path_prob` off by a rate factor, or as `thr_blk` stopping one block early or late. The comparison therefore runs after every event has settled, and across long event runs that include mispredictions and ID wrap, so that errors which build up over many steps come out. Offers made while `evt_rdy` is low would shift every later block ID, and that shift shows in `thr_blk` soon after.

// File: rtl/ppt_pkg.sv
package ppt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RDIV,
    ST_MSCAN,
    ST_MDIV,
    ST_MCLR
  } ppt_state_e;
endpackage

// File: rtl/ppt_conf_table.sv
module ppt_conf_table #(
  parameter int IDX_W  = 7,
  parameter int CONF_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [CONF_W-1:0] wr_conf,
  input  logic              inv_en,
  input  logic [IDX_W-1:0]  inv_idx,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  clr_lo,
  input  logic [IDX_W-1:0]  clr_span,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_vld,
  output logic [CONF_W-1:0] rd_conf
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0]  vld_q, vld_d;
  logic [CONF_W-1:0] conf_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [IDX_W-1:0] off;
    logic             kill;
    assign off  = IDX_W'(i) - clr_lo;
    assign kill = (clr_en && (off <= clr_span)) || (inv_en && (inv_idx == IDX_W'(i)));
    assign vld_d[i] = (wr_en && (wr_idx == IDX_W'(i))) ? 1'b1 : (kill ? 1'b0 : vld_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) conf_q[wr_idx] <= wr_conf;
  end

  assign rd_vld  = vld_q[rd_idx];
  assign rd_conf = conf_q[rd_idx];

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (inv_en || clr_en))); // R7
  AST_WRITE_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_q[$past(wr_idx)]); // R2
endmodule

// File: rtl/ppt_divider.sv
module ppt_divider #(
  parameter int P_W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [P_W-1:0] num,
  input  logic [P_W-1:0] den,
  output logic           busy,
  output logic           done,
  output logic [P_W-1:0] quo
);
  localparam int CNT_W = $clog2(P_W);

  logic [P_W:0]   rem_q, rem_d, rem_sh, den_ext;
  logic [P_W-1:0] den_q, den_d, quo_q, quo_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic           busy_q, busy_d, done_q, done_d, ge, sat;

  assign den_ext = {1'b0, den_q};
  assign rem_sh  = rem_q << 1;
  assign ge      = rem_sh >= den_ext;
  assign sat     = (den == '0) || (num >= den);

  always_comb begin
    rem_d  = rem_q;
    den_d  = den_q;
    quo_d  = quo_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (start) begin
      if (sat) begin
        quo_d  = '1;
        done_d = 1'b1;
      end else begin
        rem_d  = {1'b0, num};
        den_d  = den;
        quo_d  = '0;
        cnt_d  = CNT_W'(P_W - 1);
        busy_d = 1'b1;
      end
    end else if (busy_q) begin
      rem_d = ge ? (rem_sh - den_ext) : rem_sh;
      quo_d = {quo_q[P_W-2:0], ge};
      if (cnt_q == '0) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      den_q  <= den_d;
      quo_q  <= quo_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign quo  = quo_q;

  AST_DIV_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !start); // R5
  AST_DIV_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R5
endmodule

// File: rtl/path_prob_throttle.sv
module path_prob_throttle
  import ppt_pkg::*;
#(
  parameter int              ID_W    = 8,
  parameter int              IDX_W   = 7,
  parameter int              CONF_W  = 6,
  parameter int              P_W     = 16,
  parameter logic [P_W-1:0]  THR_RST = 16'h4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              thr_ld,
  input  logic [P_W-1:0]    thr_val,
  input  logic              fetch_vld,
  input  logic [CONF_W-1:0] fetch_conf,
  input  logic              res_vld,
  input  logic [ID_W-1:0]   res_id,
  input  logic              res_ok,
  output logic [CONF_W-1:0] rate_conf,
  input  logic [P_W-1:0]    rate_val,
  output logic              evt_rdy,
  output logic [ID_W-1:0]   thr_blk,
  output logic              thr_on,
  output logic [P_W-1:0]    path_prob
);
  localparam int DEPTH = 1 << IDX_W;

  function automatic logic id_le(input logic [ID_W-1:0] a, input logic [ID_W-1:0] b,
                                 input logic [ID_W-1:0] newest);
    logic [ID_W-1:0] base;
    base = newest - ID_W'(DEPTH - 1);
    return (a - base) <= (b - base);
  endfunction

  ppt_state_e       state_q, state_d;
  logic [P_W-1:0]   ppr_q, ppr_d, thr_q, thr_d;
  logic [ID_W-1:0]  tbr_q, tbr_d, new_q, new_d, cur_q, cur_d, mis_q, mis_d;
  logic             on_q, on_d;

  logic             pending, fetch_acc, res_acc;
  logic [ID_W-1:0]  fetch_id, walk_id;
  logic [IDX_W-1:0] rd_idx;
  logic             rd_vld;
  logic [CONF_W-1:0] rd_conf;
  logic [2*P_W-1:0] prod;
  logic [P_W-1:0]   mul_p, quo;
  logic             div_start, div_busy, div_done;

  assign pending   = (state_q == ST_IDLE) && !on_q && (tbr_q != new_q);
  assign evt_rdy   = (state_q == ST_IDLE) && !pending;
  assign fetch_acc = evt_rdy && fetch_vld;
  assign res_acc   = evt_rdy && !fetch_vld && res_vld;
  assign fetch_id  = new_q + ID_W'(1);
  assign walk_id   = tbr_q + ID_W'(1);

  always_comb begin
    if (pending)                 rd_idx = walk_id[IDX_W-1:0];
    else if (state_q == ST_IDLE) rd_idx = res_id[IDX_W-1:0];
    else                         rd_idx = cur_q[IDX_W-1:0];
  end

  assign rate_conf = fetch_acc ? fetch_conf : rd_conf;
  assign prod      = {{P_W{1'b0}}, ppr_q} * {{P_W{1'b0}}, rate_val};
  assign mul_p     = P_W'(prod >> P_W);

  ppt_conf_table #(.IDX_W(IDX_W), .CONF_W(CONF_W)) u_tab (
    .clk(clk), .rst_n(rst_n),
    .wr_en(fetch_acc), .wr_idx(fetch_id[IDX_W-1:0]), .wr_conf(fetch_conf),
    .inv_en(res_acc && res_ok), .inv_idx(res_id[IDX_W-1:0]),
    .clr_en(state_q == ST_MCLR), .clr_lo(mis_q[IDX_W-1:0]),
    .clr_span(IDX_W'(new_q - mis_q)),
    .rd_idx(rd_idx), .rd_vld(rd_vld), .rd_conf(rd_conf)
  );

  ppt_divider #(.P_W(P_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start), .num(ppr_q), .den(rate_val),
    .busy(div_busy), .done(div_done), .quo(quo)
  );

  always_comb begin
    state_d   = state_q;
    ppr_d     = ppr_q;
    tbr_d     = tbr_q;
    new_d     = new_q;
    on_d      = on_q;
    cur_d     = cur_q;
    mis_d     = mis_q;
    thr_d     = thr_ld ? thr_val : thr_q;
    div_start = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (pending) begin
          ppr_d = rd_vld ? mul_p : ppr_q;
          tbr_d = walk_id;
          on_d  = (rd_vld ? mul_p : ppr_q) < thr_q;
        end else if (fetch_acc) begin
          new_d = fetch_id;
          if (!on_q) begin
            ppr_d = mul_p;
            tbr_d = fetch_id;
            on_d  = mul_p < thr_q;
          end
        end else if (res_acc) begin
          if (res_ok) begin
            if (rd_vld && id_le(res_id, tbr_q, new_q)) begin
              div_start = 1'b1;
              state_d   = ST_RDIV;
            end
          end else begin
            mis_d   = res_id;
            cur_d   = res_id;
            state_d = ST_MSCAN;
          end
        end
      end
      ST_RDIV: begin
        if (div_done) begin
          ppr_d   = quo;
          on_d    = quo < thr_q;
          state_d = ST_IDLE;
        end
      end
      ST_MSCAN: begin
        if (!id_le(cur_q, tbr_q, new_q)) begin
          state_d = ST_MCLR;
        end else if (rd_vld) begin
          div_start = 1'b1;
          state_d   = ST_MDIV;
        end else if (cur_q == tbr_q) begin
          state_d = ST_MCLR;
        end else begin
          cur_d = cur_q + ID_W'(1);
        end
      end
      ST_MDIV: begin
        if (div_done) begin
          ppr_d = quo;
          if (cur_q == tbr_q) begin
            state_d = ST_MCLR;
          end else begin
            cur_d   = cur_q + ID_W'(1);
            state_d = ST_MSCAN;
          end
        end
      end
      ST_MCLR: begin
        new_d   = mis_q;
        if (id_le(mis_q, tbr_q, new_q)) tbr_d = mis_q;
        on_d    = ppr_q < thr_q;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ppr_q   <= '1;
      thr_q   <= THR_RST;
      tbr_q   <= '0;
      new_q   <= '0;
      on_q    <= 1'b0;
      cur_q   <= '0;
      mis_q   <= '0;
    end else begin
      state_q <= state_d;
      ppr_q   <= ppr_d;
      thr_q   <= thr_d;
      tbr_q   <= tbr_d;
      new_q   <= new_d;
      on_q    <= on_d;
      cur_q   <= cur_d;
      mis_q   <= mis_d;
    end
  end

  assign thr_blk   = tbr_q;
  assign thr_on    = on_q;
  assign path_prob = ppr_q;

  AST_FETCH_TAKES_NEXT_ID: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_acc && !on_q) |=> (thr_blk == $past(new_q) + ID_W'(1))); // R2
  AST_SET_FREEZES_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_acc && on_q) |=> ($stable(path_prob) && $stable(thr_blk) && thr_on)); // R4
  AST_WALK_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    pending |=> (thr_blk == $past(tbr_q) + ID_W'(1))); // R6
  AST_RDY_NOT_DIVIDING: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rdy |-> !div_busy); // R9
  AST_TBR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> id_le(tbr_q, new_q, new_q)); // R8
  AST_MUL_NOT_RISING: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_acc && !on_q) |=> (path_prob <= $past(path_prob))); // R3
endmodule

// File: tb/path_prob_throttle_bench.sv
module path_prob_throttle_bench;
  localparam int ID_W = 8, IDX_W = 7, CONF_W = 6, P_W = 16, DEPTH = 128;

  logic              clk = 1'b0, rst_n = 1'b0;
  logic              thr_ld = 1'b0, fetch_vld = 1'b0, res_vld = 1'b0, res_ok = 1'b0;
  logic [P_W-1:0]    thr_val = '0;
  logic [CONF_W-1:0] fetch_conf = '0;
  logic [ID_W-1:0]   res_id = '0;
  logic [CONF_W-1:0] rate_conf;
  logic [P_W-1:0]    rate_val, path_prob;
  logic              evt_rdy, thr_on;
  logic [ID_W-1:0]   thr_blk;

  always #10 clk = ~clk;

  function automatic logic [P_W-1:0] rate_of(input logic [CONF_W-1:0] c);
    if (c == 6'd63) return 16'h0000;
    return 16'hFFFF - 16'(c) * 16'd1000;
  endfunction
  assign rate_val = rate_of(rate_conf);

  path_prob_throttle u_path_prob_throttle (
    .clk(clk), .rst_n(rst_n), .thr_ld(thr_ld), .thr_val(thr_val),
    .fetch_vld(fetch_vld), .fetch_conf(fetch_conf), .res_vld(res_vld), .res_id(res_id),
    .res_ok(res_ok), .rate_conf(rate_conf), .rate_val(rate_val), .evt_rdy(evt_rdy),
    .thr_blk(thr_blk), .thr_on(thr_on), .path_prob(path_prob)
  );

  logic [P_W-1:0]    m_ppr, m_thr;
  logic [ID_W-1:0]   m_tbr, m_new;
  logic              m_on;
  logic              m_vld [DEPTH];
  logic [CONF_W-1:0] m_conf [DEPTH];
  int                n_chk = 0, n_bad = 0;
  bit                done_flag = 0, wrapped = 0;

  function automatic logic [P_W-1:0] mmul(input logic [P_W-1:0] p, input logic [P_W-1:0] r);
    return P_W'((32'(p) * 32'(r)) >> 16);
  endfunction
  function automatic logic [P_W-1:0] mdiv(input logic [P_W-1:0] p, input logic [P_W-1:0] r);
    if (r == 0 || p >= r) return 16'hFFFF;
    return P_W'((32'(p) << 16) / 32'(r));
  endfunction
  function automatic logic mle(input logic [ID_W-1:0] a, input logic [ID_W-1:0] b);
    logic [ID_W-1:0] base;
    base = m_new - ID_W'(DEPTH - 1);
    return (a - base) <= (b - base);
  endfunction

  task automatic m_walk();
    logic [ID_W-1:0] n;
    while (!m_on && m_tbr != m_new) begin
      n = m_tbr + 1;
      if (m_vld[n[IDX_W-1:0]]) m_ppr = mmul(m_ppr, rate_of(m_conf[n[IDX_W-1:0]]));
      m_tbr = n;
      m_on  = m_ppr < m_thr;
    end
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic chk(input string tag);
    n_chk++;
    if (thr_blk !== m_tbr || thr_on !== m_on || path_prob !== m_ppr) begin
      n_bad++;
      $display("FAIL %s: blk/on/prob actual %0d/%0b/%h expected %0d/%0b/%h",
               tag, thr_blk, thr_on, path_prob, m_tbr, m_on, m_ppr);
    end
  endtask

  task automatic wait_rdy();
    while (evt_rdy !== 1'b1) @(negedge clk);
  endtask

  task automatic do_fetch(input logic [CONF_W-1:0] c, input string tag);
    string t;
    wait_rdy();
    fetch_vld = 1; fetch_conf = c;
    @(negedge clk);
    fetch_vld = 0;
    t = (tag != "") ? tag : (m_on ? "R4" : "R2 R3");
    m_new = m_new + 1;
    if (m_new == 0) wrapped = 1;
    m_conf[m_new[IDX_W-1:0]] = c;
    m_vld[m_new[IDX_W-1:0]]  = 1;
    if (!m_on) begin
      m_ppr = mmul(m_ppr, rate_of(c));
      m_tbr = m_new;
      m_on  = m_ppr < m_thr;
    end
    m_walk();
    wait_rdy();
    if (wrapped && m_new < 8'd24) t = {t, " R8"};
    chk(t);
  endtask

  task automatic do_res(input logic [ID_W-1:0] id, input logic ok, input bit poke, input string tag);
    string t;
    logic [ID_W-1:0] c, span;
    bit poked;
    wait_rdy();
    res_vld = 1; res_id = id; res_ok = ok;
    @(negedge clk);
    res_vld = 0;
    poked = 0;
    if (poke && !evt_rdy) begin
      fetch_vld = 1; fetch_conf = 6'd9;
      @(negedge clk);
      fetch_vld = 0;
      poked = 1;
    end
    if (ok) begin
      if (m_vld[id[IDX_W-1:0]] && mle(id, m_tbr)) begin
        m_ppr = mdiv(m_ppr, rate_of(m_conf[id[IDX_W-1:0]]));
        m_on  = m_ppr < m_thr;
      end
      m_vld[id[IDX_W-1:0]] = 0;
    end else begin
      c = id;
      forever begin
        if (!mle(c, m_tbr)) break;
        if (m_vld[c[IDX_W-1:0]]) m_ppr = mdiv(m_ppr, rate_of(m_conf[c[IDX_W-1:0]]));
        if (c == m_tbr) break;
        c = c + 1;
      end
      span = m_new - id;
      for (int k = 0; k <= int'(span); k++) m_vld[(id + ID_W'(k)) % DEPTH] = 0;
      if (mle(id, m_tbr)) m_tbr = id;
      m_new = id;
      m_on  = m_ppr < m_thr;
    end
    m_walk();
    wait_rdy();
    t = (tag != "") ? tag : (ok ? "R5 R6" : "R7");
    if (poked) t = {t, " R9"};
    if (wrapped && m_new < 8'd24) t = {t, " R8"};
    chk(t);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected settle");
    summary();
  end

  initial begin
    int unsigned s;
    logic [ID_W-1:0] lst [DEPTH];
    int n, j;
    logic [CONF_W-1:0] cf;
    s = $urandom(32'd7);
    for (int i = 0; i < DEPTH; i++) begin m_vld[i] = 0; m_conf[i] = '0; end
    m_ppr = 16'hFFFF; m_thr = 16'h4000; m_tbr = 0; m_new = 0; m_on = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    n_chk++;
    if (thr_blk !== 0 || thr_on !== 0 || path_prob !== 16'hFFFF || evt_rdy !== 1) begin
      n_bad++;
      $display("FAIL R1: blk/on/prob/rdy actual %0d/%0b/%h/%0b expected 0/0/ffff/1",
               thr_blk, thr_on, path_prob, evt_rdy);
    end
    do_fetch(6'd20, "R2 R10");
    do_fetch(6'd20, "R3 R10");
    do_fetch(6'd20, "R3 R10");
    do_fetch(6'd20, "R3 R10");
    do_fetch(6'd3, "R4");
    do_res(8'd1, 1'b1, 1'b1, "R5 R6 R9");
    do_res(8'd5, 1'b1, 1'b0, "R5");
    @(negedge clk);
    thr_ld = 1; thr_val = 16'h8000;
    @(negedge clk);
    thr_ld = 0; m_thr = 16'h8000;
    do_fetch(6'd0, "R10");
    do_fetch(6'd63, "R3 R4");
    do_res(8'd3, 1'b0, 1'b0, "R7");
    do_fetch(6'd1, "R2 R7");
    for (int it = 0; it < 1500; it++) begin
      n = 0;
      for (int k = 0; k < DEPTH; k++) begin
        logic [ID_W-1:0] idk;
        idk = m_new - ID_W'(DEPTH - 1) + ID_W'(k);
        if (m_vld[idk[IDX_W-1:0]]) begin lst[n] = idk; n++; end
      end
      if (n < 2 || (n < 10 && ($urandom % 100) < 55)) begin
        cf = (($urandom % 16) == 0) ? 6'd63 : CONF_W'($urandom % 21);
        do_fetch(cf, "");
      end else begin
        j = ($urandom % 2) ? 0 : int'($urandom % n);
        do_res(lst[j], (($urandom % 8) != 0), bit'($urandom % 2), "");
      end
    end
    summary();
  end
endmodule